// File: doc/BRIEF.md
# Chip-Failure Tolerant Parity-Checksum Codec

This codec guards a data block that is striped across eight memory chips, one 64-bit slice per chip, plus a ninth chip that holds a parity slice. On the write side it forms the parity slice as the XOR of the eight data slices. It also forms one 8-bit checksum per slice, parity slice included, so nine checksums in all. The controller stores each checksum alongside the slice it covers.

On the read side, parity is the first line of defence. A non-zero parity syndrome means something is wrong, and it also gives the exact bit pattern needed to repair one slice. The checksums serve only to point at the slice that failed. When exactly one checksum disagrees and the syndrome is non-zero, that slice is rebuilt from parity and the other slices. Any other disagreement is reported as detected-but-uncorrectable, and the data is withheld. A weak checksum therefore costs availability, never silent corruption.

Both paths are pipelined to two clock cycles, and each has a single valid strobe. The two paths are independent and may run in the same cycle.

Top module: `chipkill_codec`

## Requirements
- R1: Two cycles after `enc_valid_i`, `enc_parity_o` equals the XOR of the eight 64-bit slices of `enc_data_i`. Slice i occupies bits 64i+63:64i.
- R2: The checksum of a slice is the 8-bit ones'-complement sum of its eight bytes, with the end-around carry folded in, so that a slice of all zeros gives 0x00. Byte i of `enc_csum_o` (bits 8i+7:8i) covers data slice i for i = 0..7. Byte 8 covers the parity slice.
- R3: Each output valid strobe is high exactly two clock cycles after the matching input strobe and is low otherwise.
- R4: With a zero syndrome (data XOR parity) and all nine recomputed checksums matching, the decoder reports status 2'b00 (clean), passes the data unchanged, and sets `dec_slot_o` to 0.
- R5: With a non-zero syndrome and only data slice k's checksum mismatching, slice k is replaced by the XOR of the parity slice and the other seven slices. Status is 2'b01 (corrected) and `dec_slot_o` = k.
- R6: With a non-zero syndrome and only the parity slice's checksum mismatching, the data passes unchanged, status is 2'b01 and `dec_slot_o` = 8.
- R7: With a non-zero syndrome and either no checksum mismatch or two or more checksum mismatches, status is 2'b10 (uncorrectable), `dec_data_o` is all zeros and `dec_slot_o` is 0.
- R8: With a zero syndrome but at least one checksum mismatch, status is 2'b10, `dec_data_o` is all zeros and `dec_slot_o` is 0.
- R9: After synchronous reset both output valids are low and `dec_status_o` is 2'b00.
- R10: Status 2'b11 is never produced on a valid decode.
- R11: When every bit of any single chip (its slice and its checksum) is replaced by arbitrary values, the decode is never clean. It is either corrected with the original data or uncorrectable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_valid_i | input | 1 | Encode request strobe |
| enc_data_i | input | 512 | Eight data slices to encode |
| enc_valid_o | output | 1 | Encode result strobe |
| enc_parity_o | output | 64 | Parity slice |
| enc_csum_o | output | 72 | Nine slice checksums, byte i for slice i, byte 8 for parity |
| dec_valid_i | input | 1 | Decode request strobe |
| dec_data_i | input | 512 | Eight data slices as read |
| dec_parity_i | input | 64 | Parity slice as read |
| dec_csum_i | input | 72 | Nine stored checksums as read |
| dec_valid_o | output | 1 | Decode result strobe |
| dec_data_o | output | 512 | Clean or repaired data, zero when uncorrectable |
| dec_status_o | output | 2 | 00 clean, 01 corrected, 10 uncorrectable |
| dec_slot_o | output | 4 | Index of the repaired slice (8 = parity), else 0 |

## Verification
The assertions assume that the reset is held for at least two cycles. They also assume that the data, parity and checksum inputs are stable in the cycle in which the input strobe is high. The stimulus meets both assumptions by driving every input on the falling edge and pulsing each strobe for a single cycle. The decode stimulus starts from codewords that are encoded correctly. Faults are then injected in controlled shapes: a whole chip wiped, a flip in a single slice, a flip in the parity slice, a flip in a checksum only, two chips at once, and a corrupted slice whose checksum was recomputed to match. These shapes reach every status branch, including the one where the checksum aliases.

// File: rtl/ckc_pkg.sv
package ckc_pkg;

  localparam int CSUM_W = 8;

  typedef enum logic [1:0] {
    ST_CLEAN  = 2'b00,
    ST_FIXED  = 2'b01,
    ST_UNCORR = 2'b10
  } dec_status_e;

  // 8-bit ones'-complement add with end-around carry
  function automatic logic [CSUM_W-1:0] oc_add(input logic [CSUM_W-1:0] a,
                                               input logic [CSUM_W-1:0] b);
    logic [CSUM_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[CSUM_W-1:0] + {{(CSUM_W-1){1'b0}}, s[CSUM_W]};
  endfunction

endpackage

// File: rtl/ckc_csum.sv
module ckc_csum
  import ckc_pkg::*;
#(
  parameter int SLICE_W = 64
) (
  input  logic [SLICE_W-1:0] slice_i,
  output logic [CSUM_W-1:0]  csum_o
);

  localparam int NBYTES = SLICE_W / CSUM_W;

  logic [CSUM_W-1:0] part [0:NBYTES];

  assign part[0] = '0;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign part[b+1] = oc_add(part[b], slice_i[b*CSUM_W +: CSUM_W]);
  end

  assign csum_o = part[NBYTES];

endmodule

// File: rtl/ckc_encoder.sv
module ckc_encoder
  import ckc_pkg::*;
#(
  parameter int N_SLICES = 8,
  parameter int SLICE_W  = 64
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           valid_i,
  input  logic [N_SLICES*SLICE_W-1:0]    data_i,
  output logic                           valid_o,
  output logic [SLICE_W-1:0]             parity_o,
  output logic [(N_SLICES+1)*CSUM_W-1:0] csum_o
);

  localparam int DCS_W = N_SLICES * CSUM_W;

  logic [SLICE_W-1:0] par_c;
  logic [DCS_W-1:0]   dcs_c;
  logic [CSUM_W-1:0]  pcs_c;

  logic               s1_valid;
  logic [SLICE_W-1:0] s1_par;
  logic [DCS_W-1:0]   s1_dcs;

  always_comb begin
    par_c = '0;
    for (int i = 0; i < N_SLICES; i++) par_c ^= data_i[i*SLICE_W +: SLICE_W];
  end

  for (genvar g = 0; g < N_SLICES; g++) begin : g_dcs
    ckc_csum #(.SLICE_W(SLICE_W)) u_cs (
      .slice_i(data_i[g*SLICE_W +: SLICE_W]),
      .csum_o (dcs_c[g*CSUM_W +: CSUM_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_par   <= '0;
      s1_dcs   <= '0;
    end else begin
      s1_valid <= valid_i;
      s1_par   <= par_c;
      s1_dcs   <= dcs_c;
    end
  end

  ckc_csum #(.SLICE_W(SLICE_W)) u_pcs (
    .slice_i(s1_par),
    .csum_o (pcs_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o  <= 1'b0;
      parity_o <= '0;
      csum_o   <= '0;
    end else begin
      valid_o  <= s1_valid;
      parity_o <= s1_par;
      csum_o   <= {pcs_c, s1_dcs};
    end
  end

  // R3: strobe appears two cycles after the request
  p_enc_lat_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> (valid_o == $past(valid_i, 2)));

endmodule

// File: rtl/ckc_decoder.sv
module ckc_decoder
  import ckc_pkg::*;
#(
  parameter int N_SLICES = 8,
  parameter int SLICE_W  = 64
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           valid_i,
  input  logic [N_SLICES*SLICE_W-1:0]    data_i,
  input  logic [SLICE_W-1:0]             parity_i,
  input  logic [(N_SLICES+1)*CSUM_W-1:0] csum_i,
  output logic                           valid_o,
  output logic [N_SLICES*SLICE_W-1:0]    data_o,
  output logic [1:0]                     status_o,
  output logic [$clog2(N_SLICES+1)-1:0]  slot_o
);

  localparam int DW   = N_SLICES * SLICE_W;
  localparam int NCS  = N_SLICES + 1;
  localparam int IDXW = $clog2(NCS);
  localparam int CNTW = $clog2(NCS + 1);

  // stage 1: syndrome and checksum comparison
  logic [SLICE_W-1:0] syn_c;
  logic [NCS-1:0]     mis_c;
  logic [CSUM_W-1:0]  rcs_c [NCS];

  always_comb begin
    syn_c = parity_i;
    for (int i = 0; i < N_SLICES; i++) syn_c ^= data_i[i*SLICE_W +: SLICE_W];
  end

  for (genvar g = 0; g < NCS; g++) begin : g_chk
    if (g < N_SLICES) begin : g_data
      ckc_csum #(.SLICE_W(SLICE_W)) u_cs (
        .slice_i(data_i[g*SLICE_W +: SLICE_W]),
        .csum_o (rcs_c[g])
      );
    end else begin : g_par
      ckc_csum #(.SLICE_W(SLICE_W)) u_cs (
        .slice_i(parity_i),
        .csum_o (rcs_c[g])
      );
    end
    assign mis_c[g] = (rcs_c[g] != csum_i[g*CSUM_W +: CSUM_W]);
  end

  logic               s1_valid;
  logic [DW-1:0]      s1_data;
  logic [SLICE_W-1:0] s1_syn;
  logic [NCS-1:0]     s1_mis;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_data  <= '0;
      s1_syn   <= '0;
      s1_mis   <= '0;
    end else begin
      s1_valid <= valid_i;
      s1_data  <= data_i;
      s1_syn   <= syn_c;
      s1_mis   <= mis_c;
    end
  end

  // stage 2: classify and rebuild
  logic [CNTW-1:0] cnt_c;
  logic [IDXW-1:0] idx_c;
  dec_status_e     st_c;
  logic [DW-1:0]   fix_c;
  logic [DW-1:0]   out_c;
  logic [IDXW-1:0] slot_c;

  always_comb begin
    cnt_c = '0;
    idx_c = '0;
    for (int i = NCS - 1; i >= 0; i--) begin
      cnt_c = cnt_c + CNTW'(s1_mis[i]);
      if (s1_mis[i]) idx_c = IDXW'(i);
    end
  end

  always_comb begin
    fix_c = s1_data;
    for (int i = 0; i < N_SLICES; i++) begin
      if (idx_c == IDXW'(i)) fix_c[i*SLICE_W +: SLICE_W] = s1_data[i*SLICE_W +: SLICE_W] ^ s1_syn;
    end
  end

  always_comb begin
    st_c   = ST_UNCORR;
    out_c  = '0;
    slot_c = '0;
    if (s1_syn == '0 && s1_mis == '0) begin
      st_c  = ST_CLEAN;
      out_c = s1_data;
    end else if (s1_syn != '0 && cnt_c == CNTW'(1)) begin
      st_c   = ST_FIXED;
      out_c  = fix_c;
      slot_c = idx_c;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o  <= 1'b0;
      data_o   <= '0;
      status_o <= ST_CLEAN;
      slot_o   <= '0;
    end else begin
      valid_o  <= s1_valid;
      data_o   <= out_c;
      status_o <= st_c;
      slot_o   <= slot_c;
    end
  end

  // R3: decode strobe two cycles after the request
  p_dec_lat_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> (valid_o == $past(valid_i, 2)));

  // R4: no syndrome and no mismatch gives clean
  p_clean_r4: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_syn == '0 && s1_mis == '0) |=> (status_o == ST_CLEAN));

  // R5: correction only with exactly one checksum mismatch
  p_fix_single_r5: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && $countones(s1_mis) != 1) |=> (status_o != ST_FIXED));

  // R7: withheld data on an uncorrectable result
  p_ue_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (valid_o && status_o == ST_UNCORR) |-> (data_o == '0 && slot_o == '0));

  // R8: parity agrees but a checksum does not
  p_parok_csbad_r8: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_syn == '0 && s1_mis != '0) |=> (status_o == ST_UNCORR));

  // R10: the unused status code never leaves the block
  p_legal_status_r10: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (status_o != 2'b11));

endmodule

// File: rtl/chipkill_codec.sv
module chipkill_codec
  import ckc_pkg::*;
#(
  parameter int N_SLICES = 8,
  parameter int SLICE_W  = 64
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           enc_valid_i,
  input  logic [N_SLICES*SLICE_W-1:0]    enc_data_i,
  output logic                           enc_valid_o,
  output logic [SLICE_W-1:0]             enc_parity_o,
  output logic [(N_SLICES+1)*CSUM_W-1:0] enc_csum_o,
  input  logic                           dec_valid_i,
  input  logic [N_SLICES*SLICE_W-1:0]    dec_data_i,
  input  logic [SLICE_W-1:0]             dec_parity_i,
  input  logic [(N_SLICES+1)*CSUM_W-1:0] dec_csum_i,
  output logic                           dec_valid_o,
  output logic [N_SLICES*SLICE_W-1:0]    dec_data_o,
  output logic [1:0]                     dec_status_o,
  output logic [$clog2(N_SLICES+1)-1:0]  dec_slot_o
);

  ckc_encoder #(.N_SLICES(N_SLICES), .SLICE_W(SLICE_W)) u_enc (
    .clk     (clk),
    .rst     (rst),
    .valid_i (enc_valid_i),
    .data_i  (enc_data_i),
    .valid_o (enc_valid_o),
    .parity_o(enc_parity_o),
    .csum_o  (enc_csum_o)
  );

  ckc_decoder #(.N_SLICES(N_SLICES), .SLICE_W(SLICE_W)) u_dec (
    .clk     (clk),
    .rst     (rst),
    .valid_i (dec_valid_i),
    .data_i  (dec_data_i),
    .parity_i(dec_parity_i),
    .csum_i  (dec_csum_i),
    .valid_o (dec_valid_o),
    .data_o  (dec_data_o),
    .status_o(dec_status_o),
    .slot_o  (dec_slot_o)
  );

endmodule

// File: tb/sim_chipkill_codec.sv
`timescale 1ns/1ps
module sim_chipkill_codec;

  localparam int N  = 8;
  localparam int W  = 64;
  localparam int DW = N * W;
  localparam int CW = (N + 1) * 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          enc_valid_i = 1'b0;
  logic [DW-1:0] enc_data_i = '0;
  logic          enc_valid_o;
  logic [W-1:0]  enc_parity_o;
  logic [CW-1:0] enc_csum_o;
  logic          dec_valid_i = 1'b0;
  logic [DW-1:0] dec_data_i = '0;
  logic [W-1:0]  dec_parity_i = '0;
  logic [CW-1:0] dec_csum_i = '0;
  logic          dec_valid_o;
  logic [DW-1:0] dec_data_o;
  logic [1:0]    dec_status_o;
  logic [3:0]    dec_slot_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  chipkill_codec u0 (
    .clk(clk), .rst(rst),
    .enc_valid_i(enc_valid_i), .enc_data_i(enc_data_i),
    .enc_valid_o(enc_valid_o), .enc_parity_o(enc_parity_o), .enc_csum_o(enc_csum_o),
    .dec_valid_i(dec_valid_i), .dec_data_i(dec_data_i),
    .dec_parity_i(dec_parity_i), .dec_csum_i(dec_csum_i),
    .dec_valid_o(dec_valid_o), .dec_data_o(dec_data_o),
    .dec_status_o(dec_status_o), .dec_slot_o(dec_slot_o)
  );

  // ---------------- reference model ----------------
  function automatic logic [7:0] m_cs(input logic [W-1:0] s);
    int unsigned t = 0;
    for (int b = 0; b < W/8; b++) t += s[b*8 +: 8];
    while (t > 255) t = (t & 255) + (t >> 8);
    return t[7:0];
  endfunction

  function automatic logic [W-1:0] m_par(input logic [DW-1:0] d);
    logic [W-1:0] p = '0;
    for (int i = 0; i < N; i++) p ^= d[i*W +: W];
    return p;
  endfunction

  function automatic logic [CW-1:0] m_css(input logic [DW-1:0] d, input logic [W-1:0] p);
    logic [CW-1:0] c;
    for (int i = 0; i < N; i++) c[i*8 +: 8] = m_cs(d[i*W +: W]);
    c[N*8 +: 8] = m_cs(p);
    return c;
  endfunction

  function automatic logic [W-1:0] m_slice(input logic [DW-1:0] d, input logic [W-1:0] p, input int k);
    return (k == N) ? p : d[k*W +: W];
  endfunction

  task automatic m_dec(input logic [DW-1:0] d, input logic [W-1:0] p, input logic [CW-1:0] c,
                       output logic [1:0] st, output logic [DW-1:0] od, output logic [3:0] sl);
    logic [W-1:0] syn = m_par(d) ^ p;
    int nm = 0;
    int who = 0;
    for (int k = 0; k <= N; k++)
      if (m_cs(m_slice(d, p, k)) != c[k*8 +: 8]) begin nm++; who = k; end
    st = 2'b10; od = '0; sl = '0;
    if (syn == '0 && nm == 0) begin st = 2'b00; od = d; end
    else if (syn != '0 && nm == 1) begin
      st = 2'b01; od = d; sl = 4'(who);
      if (who < N) begin
        logic [W-1:0] r = p;
        for (int i = 0; i < N; i++) if (i != who) r ^= d[i*W +: W];
        od[who*W +: W] = r;
      end
    end
  endtask

  function automatic logic [DW-1:0] rnd_blk();
    logic [DW-1:0] v;
    for (int i = 0; i < DW/32; i++) v[i*32 +: 32] = $urandom();
    return v;
  endfunction

  function automatic logic [W-1:0] rnd_nz();
    logic [W-1:0] v;
    do v = {$urandom(), $urandom()}; while (v == '0);
    return v;
  endfunction

  // ---------------- checking ----------------
  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // ---------------- drivers ----------------
  task automatic run_enc(input logic [DW-1:0] d, input string tag);
    @(negedge clk);
    enc_data_i = d; enc_valid_i = 1'b1;
    @(negedge clk);
    enc_valid_i = 1'b0;
    chk({tag, " R3 early"}, DW'(enc_valid_o), DW'(0));
    @(negedge clk);
    chk({tag, " R3 valid"}, DW'(enc_valid_o), DW'(1));
    chk({tag, " R1 parity"}, DW'(enc_parity_o), DW'(m_par(d)));
    chk({tag, " R2 csum"}, DW'(enc_csum_o), DW'(m_css(d, m_par(d))));
    @(negedge clk);
    chk({tag, " R3 drop"}, DW'(enc_valid_o), DW'(0));
  endtask

  logic [1:0]    got_st;
  logic [DW-1:0] got_d;
  logic [3:0]    got_sl;

  task automatic run_dec(input logic [DW-1:0] d, input logic [W-1:0] p,
                         input logic [CW-1:0] c, input string tag);
    logic [1:0] est; logic [DW-1:0] ed; logic [3:0] esl;
    m_dec(d, p, c, est, ed, esl);
    @(negedge clk);
    dec_data_i = d; dec_parity_i = p; dec_csum_i = c; dec_valid_i = 1'b1;
    @(negedge clk);
    dec_valid_i = 1'b0;
    @(negedge clk);
    got_st = dec_status_o; got_d = dec_data_o; got_sl = dec_slot_o;
    chk({tag, " R3 dvalid"}, DW'(dec_valid_o), DW'(1));
    chk({tag, " status"}, DW'(got_st), DW'(est));
    chk({tag, " data"}, got_d, ed);
    chk({tag, " slot"}, DW'(got_sl), DW'(esl));
    chk({tag, " R10 legal"}, DW'(got_st == 2'b11), DW'(0));
    @(negedge clk);
    chk({tag, " R3 ddrop"}, DW'(dec_valid_o), DW'(0));
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    logic [DW-1:0] d, bd;
    logic [W-1:0]  p, bp;
    logic [CW-1:0] c, bc;
    void'($urandom(32'h5EED_0C0D));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R9 enc_valid reset", DW'(enc_valid_o), DW'(0));
    chk("R9 dec_valid reset", DW'(dec_valid_o), DW'(0));
    chk("R9 status reset", DW'(dec_status_o), DW'(0));

    // encoder: directed and random
    run_enc('0, "enc zero R1 R2");
    run_enc('1, "enc ones R1 R2");
    chk("R2 all-ones byte csum", DW'(enc_csum_o[7:0]), DW'(8'hFF));
    for (int i = 0; i < 30; i++) run_enc(rnd_blk(), "enc rnd R1 R2");

    // R4 clean
    run_dec('0, '0, '0, "R4 zero clean");
    chk("R4 status", DW'(got_st), DW'(0));
    for (int i = 0; i < 15; i++) begin
      d = rnd_blk(); p = m_par(d); c = m_css(d, p);
      run_dec(d, p, c, "R4 clean");
      chk("R4 passthrough", got_d, d);
    end

    // R5 directed single flip in slice 3
    d = rnd_blk(); p = m_par(d); c = m_css(d, p);
    bd = d; bd[3*W + 5] = ~bd[3*W + 5];
    run_dec(bd, p, c, "R5 slice3");
    chk("R5 status", DW'(got_st), DW'(1));
    chk("R5 slot", DW'(got_sl), DW'(3));
    chk("R5 rebuilt", got_d, d);

    // R6 parity slice hit
    for (int i = 0; i < 8; i++) begin
      d = rnd_blk(); p = m_par(d); c = m_css(d, p);
      bp = p ^ rnd_nz();
      run_dec(d, bp, c, "R6 parity");
      if (m_cs(bp) != c[N*8 +: 8]) begin
        chk("R6 status", DW'(got_st), DW'(1));
        chk("R6 slot", DW'(got_sl), DW'(8));
        chk("R6 data", got_d, d);
      end
    end

    // R7 two chips
    for (int i = 0; i < 8; i++) begin
      int a = $urandom_range(0, N-1);
      int b = (a + 1 + $urandom_range(0, N-2)) % N;
      d = rnd_blk(); p = m_par(d); c = m_css(d, p);
      bd = d;
      bd[a*W +: W] = bd[a*W +: W] ^ rnd_nz();
      bd[b*W +: W] = bd[b*W +: W] ^ 64'h0000_0000_0000_0101;
      run_dec(bd, p, c, "R7 two chips");
    end

    // R7 aliasing: slice changed, checksum recomputed to match
    d = rnd_blk(); p = m_par(d);
    bd = d; bd[6*W +: W] = bd[6*W +: W] ^ 64'h0000_0000_0000_FF00;
    bd[6*W + 8 +: 8] = d[6*W + 8 +: 8] ^ 8'hFF;
    bc = m_css(bd, p);
    run_dec(bd, p, bc, "R7 alias");
    chk("R7 alias status", DW'(got_st), DW'(2));
    chk("R7 alias data zero", got_d, '0);
    chk("R7 alias slot", DW'(got_sl), DW'(0));

    // R8 checksum-only corruption
    for (int i = 0; i < 6; i++) begin
      int k = $urandom_range(0, N);
      d = rnd_blk(); p = m_par(d); c = m_css(d, p);
      bc = c; bc[k*8 +: 8] = bc[k*8 +: 8] ^ 8'h01;
      run_dec(d, p, bc, "R8 csum only");
      chk("R8 status", DW'(got_st), DW'(2));
      chk("R8 data zero", got_d, '0);
    end

    // R11 whole chip replaced by arbitrary content
    for (int i = 0; i < 50; i++) begin
      int k = $urandom_range(0, N);
      d = rnd_blk(); p = m_par(d); c = m_css(d, p);
      bd = d; bp = p; bc = c;
      if (k == N) bp = {$urandom(), $urandom()};
      else bd[k*W +: W] = {$urandom(), $urandom()};
      bc[k*8 +: 8] = 8'($urandom());
      run_dec(bd, bp, bc, "R11 chip loss");
      if (bd != d || bp != p)
        chk("R11 never clean", DW'(got_st == 2'b00), DW'(0));
      if (got_st == 2'b01) chk("R11 corrected data", got_d, d);
    end

    summary();
    $finish;
  end

endmodule